// File: doc/BRIEF.md
# Microcoded Protocol Control Sequencer

This block is a small programmable controller that steps through protocol control flow held in a microcode ROM. It fetches one 32-bit instruction per step. The next fetch address is the incremented program counter, a literal target carried in the instruction, or the top of a four-deep return stack.

ALU operands can come from four places: a 64-word scratch-pad inside the block, an external shared-memory port, a separate bus of internal hardware registers, or an 8-bit literal. ALU results go to the scratch-pad, the shared memory or the hardware register bus.

Branches test one of two things. The first is one of 32 hardware condition lines, which are wired straight into the branch logic, so no register read is needed to sample them. The second is the zero, carry or negative flag left by the last ALU operation. The block does nothing until its enable input is raised.

Top module: `useq_core`

## Requirements
- R1: While reset is asserted and afterwards, until `en` is first high at the start of an instruction, the PC is 0, the flags `{n,c,z}` read 3'b000, `err` is 0, the return stack is empty and no instruction executes. An instruction that has not yet started does not start while `en` is low.
- R2: Instruction word fields:
  - bits [31:27] are the opcode.
  - bits [26:17] are operand A: a tag in [26:25] and an index in [24:17].
  - bits [16:7] are operand B: a tag in [16:15] and an index in [14:7].
  - bits [6:0] are the field F.
  - When opcode[4:3] is not 2'b11, the instruction is an ALU operation, and the PC advances by 1 once it executes.
- R3: Operand tags select the source:
  - 00 is the scratch-pad word at index[5:0], read in the same cycle.
  - 01 is shared memory at the index.
  - 10 is the hardware register bus at the index.
  - 11 is the literal: the index zero-extended to 16 bits.
- R4: Execution timing for ALU instructions:
  - With only scratch-pad or literal operands, an ALU instruction executes in 1 cycle.
  - With one or two port operands on different ports, it takes 2 cycles. Both reads are issued in the first cycle and consumed one cycle later.
  - With both operands on the same port, it takes 3 cycles. The A read is issued first and the B read one cycle later.
  - The PC holds during the stall cycles.
- R5: ALU operations are selected by opcode[2:0]:
  - 0 is add. The carry flag is the carry out.
  - 1 is subtract A−B. The carry flag is the borrow.
  - 2 is AND, 3 is OR and 4 is XOR. The carry flag is 0.
  - 5 is shift left of A by B[3:0], and 6 is shift right. The carry flag is the last bit shifted out, or 0 for a shift of 0.
  - 7 is compare. It sets the flags as a subtract does and writes nothing.
  - Every ALU operation sets the zero flag when the result is 0 and the negative flag to result bit 15.
- R6: opcode[4:3] selects the ALU destination:
  - 00 writes the scratch-pad at F[5:0].
  - 01 writes shared memory at {0,F}.
  - 10 writes the hardware registers at {0,F}.
  - Each port write is a one-cycle strobe, issued in the execute cycle.
- R7: Control opcodes:
  - 5'b11001 jumps to F.
  - 5'b11010 pushes PC+1 and jumps to F.
  - 5'b11011 pops the stack into the PC.
  - 5'b11000, 5'b11110 and 5'b11111 only advance the PC.
  - Control opcodes leave the flags unchanged.
- R8: Opcode 5'b11100 branches to F when condition line A.index[4:0] equals polarity bit B.index[0]. Otherwise it falls through to PC+1.
- R9: Opcode 5'b11101 branches to F when the flag selected by A.index[1:0] equals B.index[0]. Selector 0 is zero, 1 is carry, 2 is negative, and 3 reads as 0. An instruction skipped by a taken branch has no effect.
- R10: A push onto a full stack (4 entries) or a pop from an empty stack leaves the stack unchanged, holds the PC on that instruction and sets `err`. `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows a new instruction to start |
| rom_addr | output | 7 | Microcode fetch address (the PC) |
| rom_data | input | 32 | Instruction at `rom_addr`, combinational |
| cond | input | 32 | Hardware condition lines |
| shm_addr | output | 8 | Shared-memory address |
| shm_rd | output | 1 | Shared-memory read strobe, data due next cycle |
| shm_wr | output | 1 | Shared-memory write strobe |
| shm_wdata | output | 16 | Shared-memory write data |
| shm_rdata | input | 16 | Shared-memory read data |
| hwr_addr | output | 8 | Hardware register bus address |
| hwr_rd | output | 1 | Hardware register read strobe, data due next cycle |
| hwr_wr | output | 1 | Hardware register write strobe |
| hwr_wdata | output | 16 | Hardware register write data |
| hwr_rdata | input | 16 | Hardware register read data |
| flags | output | 3 | ALU flags {negative, carry, zero} |
| err | output | 1 | Sticky stack fault |

## Verification
The PC, the flags and `err` are registered, so the effect of an instruction that executes in a cycle shows after the following rising edge. An instruction with a port operand therefore moves the PC two edges after it starts, and one with two operands on the same port moves it three edges after. The bench model steps at each rising edge with the same stall rules, and every output is compared half a cycle later at the falling edge, where it has settled. Port writes are compared through the final memory images and through targeted checks once the program has come to rest.

// File: rtl/useq_core.sv
module useq_core #(
  parameter int DW    = 16,
  parameter int NCOND = 32,
  parameter int SPD   = 64,
  parameter int STK   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [6:0]       rom_addr,
  input  logic [31:0]      rom_data,
  input  logic [NCOND-1:0] cond,
  output logic [7:0]       shm_addr,
  output logic             shm_rd,
  output logic             shm_wr,
  output logic [DW-1:0]    shm_wdata,
  input  logic [DW-1:0]    shm_rdata,
  output logic [7:0]       hwr_addr,
  output logic             hwr_rd,
  output logic             hwr_wr,
  output logic [DW-1:0]    hwr_wdata,
  input  logic [DW-1:0]    hwr_rdata,
  output logic [2:0]       flags,
  output logic             err
);
  localparam int AW  = 7;
  localparam int SPW = $clog2(SPD);
  localparam int CW  = $clog2(NCOND);
  localparam int SHW = $clog2(DW);
  localparam int SW  = $clog2(STK + 1);
  localparam int IXW = $clog2(STK);
  localparam logic [1:0] T_SCR = 2'd0, T_SHM = 2'd1, T_HWR = 2'd2, T_LIT = 2'd3;

  logic [AW-1:0] pc, npc;
  logic [1:0]    ph;
  logic [SW-1:0] sp, spm1;
  logic          zf, cf, nf;
  logic [DW-1:0] alat;
  logic [DW-1:0] scr [SPD];
  logic [AW-1:0] stk [STK];

  wire [4:0] op = rom_data[31:27];
  wire [1:0] ta = rom_data[26:25];
  wire [7:0] ia = rom_data[24:17];
  wire [1:0] tb = rom_data[16:15];
  wire [7:0] ib = rom_data[14:7];
  wire [6:0] fld = rom_data[6:0];

  wire alu   = op[4:3] != 2'b11;
  wire need_a = alu && (ta == T_SHM || ta == T_HWR);
  wire need_b = alu && (tb == T_SHM || tb == T_HWR);
  wire same  = need_a && need_b && (ta == tb);
  wire exec  = (ph == 2'd0 && en && !need_a && !need_b) || (ph == 2'd1 && !same) || ph == 2'd2;

  wire [DW-1:0] port_a = (ta == T_SHM) ? shm_rdata : hwr_rdata;
  wire [DW-1:0] port_b = (tb == T_SHM) ? shm_rdata : hwr_rdata;
  logic [DW-1:0] opa, opb;

  always_comb begin
    case (ta)
      T_SCR:   opa = scr[ia[SPW-1:0]];
      T_LIT:   opa = {{(DW-8){1'b0}}, ia};
      default: opa = (ph == 2'd2) ? alat : port_a;
    endcase
    case (tb)
      T_SCR:   opb = scr[ib[SPW-1:0]];
      T_LIT:   opb = {{(DW-8){1'b0}}, ib};
      default: opb = port_b;
    endcase
  end

  logic [DW:0] x;
  logic [DW:0] rtmp;
  wire [SHW-1:0] sh = opb[SHW-1:0];
  always_comb begin
    rtmp = '0;
    case (op[2:0])
      3'd0:        x = {1'b0, opa} + {1'b0, opb};
      3'd1, 3'd7:  x = {1'b0, opa} - {1'b0, opb};
      3'd2:        x = {1'b0, opa & opb};
      3'd3:        x = {1'b0, opa | opb};
      3'd4:        x = {1'b0, opa ^ opb};
      3'd5:        x = {1'b0, opa} << sh;
      default: begin
        rtmp = {opa, 1'b0} >> sh;
        x = {rtmp[0], rtmp[DW:1]};
      end
    endcase
  end
  wire [DW-1:0] res = x[DW-1:0];

  wire wen = exec && alu && op[2:0] != 3'd7;
  assign shm_wr = wen && op[4:3] == 2'b01;
  assign hwr_wr = wen && op[4:3] == 2'b10;
  assign shm_wdata = res;
  assign hwr_wdata = res;
  assign shm_rd = (ph == 2'd0 && en && alu && (ta == T_SHM || tb == T_SHM)) ||
                  (ph == 2'd1 && same && tb == T_SHM);
  assign hwr_rd = (ph == 2'd0 && en && alu && (ta == T_HWR || tb == T_HWR)) ||
                  (ph == 2'd1 && same && tb == T_HWR);
  assign shm_addr = shm_wr ? {1'b0, fld} : (ph == 2'd0 && ta == T_SHM) ? ia : ib;
  assign hwr_addr = hwr_wr ? {1'b0, fld} : (ph == 2'd0 && ta == T_HWR) ? ia : ib;

  wire [3:0] fsel = {1'b0, nf, cf, zf};
  logic push, pop, fault;
  assign spm1 = sp - 1'b1;
  always_comb begin
    npc = pc + 1'b1;
    push = 1'b0;
    pop = 1'b0;
    fault = 1'b0;
    if (!alu) begin
      case (op[2:0])
        3'd1: npc = fld;
        3'd2: if (sp == SW'(STK)) begin fault = 1'b1; npc = pc; end
              else begin push = 1'b1; npc = fld; end
        3'd3: if (sp == '0) begin fault = 1'b1; npc = pc; end
              else begin pop = 1'b1; npc = stk[spm1[IXW-1:0]]; end
        3'd4: if (cond[ia[CW-1:0]] == ib[0]) npc = fld;
        3'd5: if (fsel[ia[1:0]] == ib[0]) npc = fld;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ph <= 2'd0;
      sp <= '0;
      {nf, cf, zf} <= 3'b000;
      err <= 1'b0;
      alat <= '0;
      for (int i = 0; i < SPD; i++) scr[i] <= '0;
      for (int i = 0; i < STK; i++) stk[i] <= '0;
    end else begin
      case (ph)
        2'd0:    if (en && (need_a || need_b)) ph <= 2'd1;
        2'd1:    ph <= same ? 2'd2 : 2'd0;
        default: ph <= 2'd0;
      endcase
      if (ph == 2'd1 && same) alat <= port_a;
      if (exec) pc <= npc;
      if (exec && alu) {nf, cf, zf} <= {res[DW-1], x[DW], res == '0};
      if (wen && op[4:3] == 2'b00) scr[fld[SPW-1:0]] <= res;
      if (exec && push) begin
        stk[sp[IXW-1:0]] <= pc + 1'b1;
        sp <= sp + 1'b1;
      end
      if (exec && pop) sp <= spm1;
      if (exec && fault) err <= 1'b1;
    end
  end

  assign rom_addr = pc;
  assign flags = {nf, cf, zf};

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= SW'(STK)); // R10
  AST_ERR_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R10
  AST_FAULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> pc == $past(pc)); // R10
  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (ph == 2'd0 && !en) |=> $stable(pc) && $stable(flags)); // R1
  AST_READ_STALL:  assert property (@(posedge clk) disable iff (!rst_n) (shm_rd || hwr_rd) |=> $stable(pc)); // R4
  AST_SHM_ONE_OP:  assert property (@(posedge clk) disable iff (!rst_n) !(shm_rd && shm_wr)); // R4
  AST_HWR_ONE_OP:  assert property (@(posedge clk) disable iff (!rst_n) !(hwr_rd && hwr_wr)); // R6
endmodule

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [6:0] rom_addr;
  logic [31:0] rom_data;
  logic [31:0] cond = '0;
  logic [7:0] shm_addr, hwr_addr;
  logic shm_rd, shm_wr, hwr_rd, hwr_wr;
  logic [15:0] shm_wdata, hwr_wdata, shm_q, hwr_q;
  logic [2:0] flags;
  logic err;

  logic [31:0] rom [128];
  logic [15:0] shm_mem [256];
  logic [15:0] hwr_mem [256];

  int nchk = 0, nfail = 0, cyc = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  useq_core dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rom_addr(rom_addr), .rom_data(rom_data), .cond(cond),
    .shm_addr(shm_addr), .shm_rd(shm_rd), .shm_wr(shm_wr), .shm_wdata(shm_wdata), .shm_rdata(shm_q),
    .hwr_addr(hwr_addr), .hwr_rd(hwr_rd), .hwr_wr(hwr_wr), .hwr_wdata(hwr_wdata), .hwr_rdata(hwr_q),
    .flags(flags), .err(err)
  );

  assign rom_data = rom[rom_addr];

  always @(posedge clk) begin
    if (shm_rd) shm_q <= shm_mem[shm_addr];
    if (shm_wr) shm_mem[shm_addr] <= shm_wdata;
    if (hwr_rd) hwr_q <= hwr_mem[hwr_addr];
    if (hwr_wr) hwr_mem[hwr_addr] <= hwr_wdata;
  end

  // behavioural reference model
  int m_pc, m_ph, m_z, m_c, m_n, m_err;
  int m_scr[64];
  int m_shm[256];
  int m_hwr[256];
  int m_stk[$];

  function automatic int rd_op(int t, int i);
    case (t)
      0: return m_scr[i % 64];
      1: return m_shm[i];
      2: return m_hwr[i];
      default: return i;
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 0; m_ph = 0; m_z = 0; m_c = 0; m_n = 0; m_err = 0;
    m_stk.delete();
    for (int i = 0; i < 64; i++) m_scr[i] = 0;
  endtask

  task automatic model_step();
    logic [31:0] w;
    int op, ta, ia, tb, ib, f, a, b, r, c, sh, s, isalu, na, nb, fv;
    w = rom[m_pc];
    op = int'(w[31:27]); ta = int'(w[26:25]); ia = int'(w[24:17]);
    tb = int'(w[16:15]); ib = int'(w[14:7]); f = int'(w[6:0]);
    isalu = (op / 8) != 3;
    na = isalu && (ta == 1 || ta == 2);
    nb = isalu && (tb == 1 || tb == 2);
    if (m_ph == 0 && !en) return;
    if (m_ph == 0 && (na || nb)) begin m_ph = 1; return; end
    if (m_ph == 1 && na && nb && ta == tb) begin m_ph = 2; return; end
    m_ph = 0;
    if (isalu) begin
      a = rd_op(ta, ia); b = rd_op(tb, ib); sh = b % 16; c = 0;
      case (op % 8)
        0: begin s = a + b; r = s % 65536; c = s / 65536; end
        1, 7: begin r = (a - b + 65536) % 65536; c = (a < b); end
        2: r = a & b;
        3: r = a | b;
        4: r = a ^ b;
        5: begin s = a << sh; r = s % 65536; c = (s >> 16) & 1; end
        default: begin r = a >> sh; c = (sh == 0) ? 0 : (a >> (sh - 1)) & 1; end
      endcase
      m_z = (r == 0); m_c = c; m_n = (r >> 15) & 1;
      if (op % 8 != 7) begin
        case (op / 8)
          0: m_scr[f % 64] = r;
          1: m_shm[f] = r;
          default: m_hwr[f] = r;
        endcase
      end
      m_pc = (m_pc + 1) % 128;
    end else begin
      case (op % 8)
        1: m_pc = f;
        2: if (m_stk.size() == 4) m_err = 1; else begin m_stk.push_back((m_pc + 1) % 128); m_pc = f; end
        3: if (m_stk.size() == 0) m_err = 1; else m_pc = m_stk.pop_back();
        4: m_pc = (int'(cond[ia % 32]) == (ib & 1)) ? f : (m_pc + 1) % 128;
        5: begin
          fv = (ia % 4 == 0) ? m_z : (ia % 4 == 1) ? m_c : (ia % 4 == 2) ? m_n : 0;
          m_pc = (fv == (ib & 1)) ? f : (m_pc + 1) % 128;
        end
        default: m_pc = (m_pc + 1) % 128;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2/R4/R7 pc", int'(rom_addr), m_pc);
      chk("R5 flags", int'(flags), m_n * 4 + m_c * 2 + m_z);
      chk("R10 err", int'(err), m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [31:0] enc(int op, int ta, int ia, int tb, int ib, int f);
    return {op[4:0], ta[1:0], ia[7:0], tb[1:0], ib[7:0], f[6:0]};
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 128; i++) rom[i] = enc(24, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      shm_mem[i] = 16'(i * 29 + 7);
      hwr_mem[i] = 16'(i * 11 + 3);
    end
    shm_mem[20] = 16'h1234; shm_mem[21] = 16'h00FF; hwr_mem[5] = 16'h0011;
    for (int i = 0; i < 256; i++) begin
      m_shm[i] = int'(shm_mem[i]);
      m_hwr[i] = int'(hwr_mem[i]);
    end
    clear_rom();
    rom[0]   = enc(0, 3, 5, 3, 7, 1);          // R3 literals -> scratch 1
    rom[1]   = enc(9, 0, 1, 3, 12, 10);        // R5 sub -> shm[10]
    rom[2]   = enc(29, 0, 0, 0, 1, 4);         // R9 zero set -> 4
    rom[3]   = enc(8, 3, 1, 3, 1, 0);          // skipped
    rom[4]   = enc(16, 1, 20, 2, 5, 3);        // R4 two ports -> hwr[3]
    rom[5]   = enc(12, 1, 20, 1, 21, 11);      // R4 same port -> shm[11]
    rom[6]   = enc(5, 3, 8'hC0, 3, 9, 2);      // R5 shl
    rom[7]   = enc(6, 0, 2, 3, 15, 3);         // R5 shr
    rom[8]   = enc(28, 0, 3, 0, 1, 10);        // R8 cond[3]==1 -> 10
    rom[9]   = enc(8, 3, 1, 3, 1, 1);          // skipped
    rom[10]  = enc(26, 0, 0, 0, 0, 80);        // R7 call chain
    rom[80]  = enc(26, 0, 0, 0, 0, 90);
    rom[90]  = enc(26, 0, 0, 0, 0, 100);
    rom[100] = enc(26, 0, 0, 0, 0, 110);
    rom[110] = enc(27, 0, 0, 0, 0, 0);
    rom[101] = enc(27, 0, 0, 0, 0, 0);
    rom[91]  = enc(27, 0, 0, 0, 0, 0);
    rom[81]  = enc(27, 0, 0, 0, 0, 0);
    rom[11]  = enc(8, 0, 3, 0, 1, 12);
    rom[12]  = enc(10, 3, 8'hF0, 1, 11, 13);
    rom[13]  = enc(28, 0, 7, 0, 1, 70);        // R8 not taken
    rom[14]  = enc(29, 0, 1, 0, 0, 16);        // R9 carry clear -> 16
    rom[15]  = enc(8, 3, 1, 3, 1, 2);          // skipped
    rom[16]  = enc(7, 3, 3, 3, 5, 0);          // R5 compare, no write
    rom[17]  = enc(29, 0, 2, 0, 1, 19);        // R9 negative -> 19
    rom[18]  = enc(8, 3, 1, 3, 1, 3);          // skipped
    rom[19]  = enc(8, 0, 0, 3, 0, 14);
    rom[20]  = enc(25, 0, 0, 0, 0, 60);        // R7 jump
    for (int i = 60; i < 65; i++) rom[i] = enc(26, 0, 0, 0, 0, i + 1);
    cond = 32'h1000_0008;

    repeat (3) @(negedge clk);
    chk("R1 reset pc", int'(rom_addr), 0);
    chk("R1 reset flags", int'(flags), 0);
    chk("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle pc", int'(rom_addr), 0);
    chk("R1 idle no write", int'(shm_wr || hwr_wr), 0);
    for (int c = 0; c < 300; c++) begin
      en = (c % 5 != 2);
      @(negedge clk);
    end
    chk("R5 R6 sub to shm", int'(shm_mem[10]), 0);
    chk("R3 R4 two-port add", int'(hwr_mem[3]), 16'h1245);
    chk("R4 same-port xor", int'(shm_mem[11]), 16'h12CB);
    chk("R7 after returns", int'(shm_mem[12]), 13);
    chk("R5 and", int'(shm_mem[13]), 16'h00C0);
    chk("R5 compare no write", int'(shm_mem[14]), 0);
    for (int k = 0; k < 4; k++) chk("R8 R9 skipped instr", int'(shm_mem[k]), int'(16'(k * 29 + 7)));
    chk("R10 overflow pc held", int'(rom_addr), 64);
    chk("R10 overflow err", int'(err), 1);
    chk("R5 final flags", int'(flags), 1);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++)
        if (int'(shm_mem[i]) != m_shm[i] || int'(hwr_mem[i]) != m_hwr[i]) bad++;
      chk("R6 memory images", bad, 0);
    end

    cmp_on = 0;
    en = 1'b0;
    rst_n = 1'b0;
    clear_rom();
    rom[0] = enc(27, 0, 0, 0, 0, 0);           // R10 pop on empty
    repeat (2) @(negedge clk);
    chk("R1 reset clears err", int'(err), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    en = 1'b1;
    @(negedge clk);
    chk("R10 underflow err", int'(err), 1);
    chk("R10 underflow pc", int'(rom_addr), 0);
    repeat (4) @(negedge clk);
    chk("R10 err sticky", int'(err), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule